// File: doc/BRIEF.md
# Saturating Stereo Mix Accumulator

This block adds one voice into a stereo output buffer of 1024 frames that sits in a local single-port RAM. Each frame takes two 16-bit words, the right channel at the even address and the left channel at the odd address after it. For every frame that the pass covers, the block reads both stored words. It adds the incoming right and left samples to them as signed values, clamps each sum to the 16-bit signed range and writes the results back to the same addresses. Several voices can be layered into one buffer by running one pass per voice.

A pass begins with a one-cycle `start`. The `clear_mode` and `delay_in` values are sampled on that same cycle. In clear mode the block first writes zero to all 2048 words. Otherwise it keeps the current contents. The delay value is a count of frames that the voice should not yet sound. The block steps over that many frames from the start of the buffer, one frame per cycle, and leaves them untouched. If the delay is longer than the buffer, the pass does no mixing at all. The unused part of the delay is left on `delay_left` so the caller can pass it into the next pass.

Sample pairs come in over a valid/ready handshake. The block raises ready only when it is waiting for the next frame, which is after both words of the previous frame have been written back. So an accepted pair tells the sample fetcher to move on. A one-cycle `done` marks the end of the pass.

Top module: `mixacc_top`

## Requirements
- R1: Frame f (0 to 1023) uses RAM word 2f for the right sample and word 2f+1 for the left sample. The RAM is never read and written in the same cycle.
- R2: For every mixed frame the block reads word 2f and then word 2f+1. Each write-back goes to the address that was read two cycles earlier. The stored value is the signed sum of the old word and the new sample, with the right channel handled before the left.
- R3: A sum above 32767 is written as 32767 (0x7FFF). A sum below -32768 is written as -32768 (0x8000).
- R4: For a delay D, the first min(D, 1024) frames keep their contents. During the delay phase the block makes no RAM access and accepts no sample, so the first read of the pass goes to word 2·min(D, 1024).
- R5: When `done` is high, `delay_left` holds D - min(D, 1024). For D of 1024 or more, no frame is mixed.
- R6: With `clear_mode` = 1, all 2048 words are written to zero before any mixing. With `clear_mode` = 0, frames that are not mixed keep their earlier values.
- R7: `smp_ready` is high only in cycles with no RAM access, after the previous frame's two writes. Exactly one pair is accepted for each mixed frame, which is 1024 - min(D, 1024) pairs per pass.
- R8: `done` is high for exactly one cycle after the last write of the pass. `busy` is high from the cycle after `start` through the `done` cycle.
- R9: While `rst_n` is low and after it is released, `busy`, `done`, `smp_ready`, `ram_we` and `ram_re` are low and `delay_left` is 0. This holds when reset is applied in the middle of a pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a pass (ignored while busy) |
| clear_mode | input | 1 | Sampled with start: 1 zeroes the buffer before mixing |
| delay_in | input | 32 | Sampled with start: frames to skip before mixing |
| smp_valid | input | 1 | A sample pair is presented |
| smp_right | input | 16 | Signed right sample of the pair |
| smp_left | input | 16 | Signed left sample of the pair |
| smp_ready | output | 1 | The block takes the presented pair on this cycle |
| ram_addr | output | 11 | Word address into the buffer RAM |
| ram_re | output | 1 | Read strobe; data returns on ram_rdata one cycle later |
| ram_we | output | 1 | Write strobe |
| ram_wdata | output | 16 | Write data |
| ram_rdata | input | 16 | Read data from the RAM |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| delay_left | output | 32 | Delay still owed after the pass |

## Verification
The delay running out and the buffer coming to its end can fall in the same cycle. This is the case when the delay equals the frame count, or is one less than it. The stimulus table drives delays of 1023, 1024 and 1500. For each one the bench judges three things: the carried-over count on `delay_left`, the number of pairs accepted, and the first read address, which must be the single last frame or no read at all. Spot checks on saturated words sit next to skipped frames. These show that a frame the delay skips is not also mixed.

// File: rtl/mixacc_pkg.sv
// Shared definitions for the stereo mix accumulator.
// Assumes: nothing beyond the standard language.
package mixacc_pkg;

    // Sequencer states: one pass walks CLEAR (optional), DELAY, then the
    // per-frame loop ACCEPT -> RD_R -> RD_L -> WR_R -> WR_L, and ends in DONE.
    typedef enum logic [3:0] {
        S_IDLE,
        S_CLEAR,
        S_DELAY,
        S_ACCEPT,
        S_RD_R,
        S_RD_L,
        S_WR_R,
        S_WR_L,
        S_DONE
    } mix_state_e;

endpackage

// File: rtl/mixacc_lane.sv
// Saturating adder lane with a registered result.
// Adds a signed stored word to a signed sample and clamps the sum to the
// SW-bit signed range. The result is captured when en is high.
// Assumes: both operands are two's complement and SW bits wide.
module mixacc_lane #(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [SW-1:0] stored,
    input  logic [SW-1:0] sample,
    output logic [SW-1:0] sum_q
);

    localparam logic [SW-1:0] MAX_POS = {1'b0, {(SW-1){1'b1}}};
    localparam logic [SW-1:0] MAX_NEG = {1'b1, {(SW-1){1'b0}}};

    logic [SW:0]   wide;
    logic          ovf;
    logic [SW-1:0] clamped;

    // Widen by one sign bit, add, and clamp when the top two bits differ.
    always_comb begin
        wide    = {stored[SW-1], stored} + {sample[SW-1], sample};
        ovf     = wide[SW] ^ wide[SW-1];
        clamped = ovf ? (wide[SW] ? MAX_NEG : MAX_POS) : wide[SW-1:0];
    end

    // Hold the clamped sum for the write-back cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)  sum_q <= '0;
        else if (en) sum_q <= clamped;
    end

endmodule

// File: rtl/mixacc_delay.sv
// Frame delay counter.
// Loads the requested delay at the start of a pass and counts down by one
// for each frame that is skipped. What is left over is the delay carried
// into the next pass.
// Assumes: step is never asserted while the count is zero.
module mixacc_delay #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          step,
    output logic [DW-1:0] cnt_q,
    output logic          zero
);

    // Load on pass start, otherwise count down one skipped frame per step.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (step) cnt_q <= cnt_q - 1'b1;
    end

    // Flag the point where the delay has run out.
    always_comb zero = (cnt_q == '0);

endmodule

// File: rtl/mixacc_ctrl.sv
// Pass sequencer for the mix accumulator.
// Runs the optional clear sweep, steps over delayed frames one per cycle,
// then handles each remaining frame as accept, read right, read left,
// write right, write left. It also drives the RAM address and strobes.
// Assumes: the RAM returns read data one cycle after the read strobe.
module mixacc_ctrl
    import mixacc_pkg::*;
#(
    parameter int FRAMES = 1024,
    parameter int AW     = $clog2(2 * FRAMES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          clear_mode,
    input  logic          smp_valid,
    input  logic          dly_zero,
    output logic          dly_load,
    output logic          dly_step,
    output logic          cap_smp,
    output logic          lane_en,
    output logic          lane_left,
    output logic          wdata_zero,
    output logic [AW-1:0] ram_addr,
    output logic          ram_re,
    output logic          ram_we,
    output logic          smp_ready,
    output logic          busy,
    output logic          done,
    output logic          clear_phase,
    output logic          delay_phase
);

    localparam int          WORDS     = 2 * FRAMES;
    localparam logic [AW-1:0] FRAMES_V  = AW'(FRAMES);
    localparam logic [AW-1:0] LAST_FRM  = AW'(FRAMES - 1);
    localparam logic [AW-1:0] LAST_WORD = AW'(WORDS - 1);

    mix_state_e    state, nxt;
    logic [AW-1:0] wc;   // clear sweep word counter
    logic [AW-1:0] fc;   // frame counter, may reach FRAMES
    logic [AW-1:0] base; // even word address of the current frame

    // Next-state selection for the pass sequence.
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (start) nxt = clear_mode ? S_CLEAR : S_DELAY;
            S_CLEAR:  if (wc == LAST_WORD) nxt = S_DELAY;
            S_DELAY: begin
                if (fc == FRAMES_V) nxt = S_DONE;
                else if (dly_zero)  nxt = S_ACCEPT;
            end
            S_ACCEPT: if (smp_valid) nxt = S_RD_R;
            S_RD_R:   nxt = S_RD_L;
            S_RD_L:   nxt = S_WR_R;
            S_WR_R:   nxt = S_WR_L;
            S_WR_L:   nxt = (fc == LAST_FRM) ? S_DONE : S_ACCEPT;
            S_DONE:   nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            wc    <= '0;
            fc    <= '0;
        end else begin
            state <= nxt;
            case (state)
                S_IDLE: if (start) begin
                    wc <= '0;
                    fc <= '0;
                end
                S_CLEAR: wc <= wc + 1'b1;
                S_DELAY: if (dly_step) fc <= fc + 1'b1;
                S_WR_L:  fc <= fc + 1'b1;
                default: ;
            endcase
        end
    end

    // Strobes, address and handshake decoded from the state.
    always_comb begin
        base        = {fc[AW-2:0], 1'b0};
        dly_load    = (state == S_IDLE) && start;
        dly_step    = (state == S_DELAY) && (fc != FRAMES_V) && !dly_zero;
        smp_ready   = (state == S_ACCEPT);
        cap_smp     = (state == S_ACCEPT) && smp_valid;
        lane_en     = (state == S_RD_L) || (state == S_WR_R);
        lane_left   = (state == S_WR_R);
        wdata_zero  = (state == S_CLEAR);
        ram_re      = (state == S_RD_R) || (state == S_RD_L);
        ram_we      = (state == S_CLEAR) || (state == S_WR_R) || (state == S_WR_L);
        busy        = (state != S_IDLE);
        done        = (state == S_DONE);
        clear_phase = (state == S_CLEAR);
        delay_phase = (state == S_DELAY);
        unique case (state)
            S_CLEAR:        ram_addr = wc;
            S_RD_L, S_WR_L: ram_addr = base | AW'(1);
            default:        ram_addr = base;
        endcase
    end

endmodule

// File: rtl/mixacc_top.sv
// Saturating stereo mix accumulator, top level.
// Mixes one voice into an interleaved stereo buffer in an external
// single-port RAM (right word even, left word odd). It can clear the buffer
// first, honours a frame delay, and hands back the delay it did not use.
// Assumes: the RAM has a one-cycle read latency; start is a single-cycle
// pulse and is ignored while a pass runs.
module mixacc_top #(
    parameter int FRAMES = 1024,
    parameter int SW     = 16,
    parameter int DW     = 32,
    parameter int AW     = $clog2(2 * FRAMES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          clear_mode,
    input  logic [DW-1:0] delay_in,
    input  logic          smp_valid,
    input  logic [SW-1:0] smp_right,
    input  logic [SW-1:0] smp_left,
    output logic          smp_ready,
    output logic [AW-1:0] ram_addr,
    output logic          ram_re,
    output logic          ram_we,
    output logic [SW-1:0] ram_wdata,
    input  logic [SW-1:0] ram_rdata,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] delay_left
);

    logic          dly_load, dly_step, dly_zero;
    logic          cap_smp, lane_en, lane_left, wdata_zero;
    logic          clear_phase, delay_phase;
    logic [SW-1:0] hold_r, hold_l, lane_smp, lane_sum;

    mixacc_ctrl #(.FRAMES(FRAMES), .AW(AW)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .clear_mode (clear_mode),
        .smp_valid  (smp_valid),
        .dly_zero   (dly_zero),
        .dly_load   (dly_load),
        .dly_step   (dly_step),
        .cap_smp    (cap_smp),
        .lane_en    (lane_en),
        .lane_left  (lane_left),
        .wdata_zero (wdata_zero),
        .ram_addr   (ram_addr),
        .ram_re     (ram_re),
        .ram_we     (ram_we),
        .smp_ready  (smp_ready),
        .busy       (busy),
        .done       (done),
        .clear_phase(clear_phase),
        .delay_phase(delay_phase)
    );

    mixacc_delay #(.DW(DW)) delay_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (dly_load),
        .load_val(delay_in),
        .step    (dly_step),
        .cnt_q   (delay_left),
        .zero    (dly_zero)
    );

    // Hold the accepted pair until both of its words are written back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_r <= '0;
            hold_l <= '0;
        end else if (cap_smp) begin
            hold_r <= smp_right;
            hold_l <= smp_left;
        end
    end

    // Choose the channel that the lane adds in this cycle.
    always_comb lane_smp = lane_left ? hold_l : hold_r;

    mixacc_lane #(.SW(SW)) lane_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (lane_en),
        .stored(ram_rdata),
        .sample(lane_smp),
        .sum_q (lane_sum)
    );

    // Write zeros during the clear sweep, otherwise the clamped sum.
    always_comb ram_wdata = wdata_zero ? '0 : lane_sum;

endmodule

// File: rtl/mixacc_chk.sv
// Property checker for mixacc_top, attached by bind.
// Watches the RAM strobes, the sample handshake and the pass phases.
// Assumes: synchronous active-low reset, as in the design.
module mixacc_chk #(
    parameter int AW = 11,
    parameter int SW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_valid,
    input logic          smp_ready,
    input logic [AW-1:0] ram_addr,
    input logic          ram_re,
    input logic          ram_we,
    input logic [SW-1:0] ram_wdata,
    input logic          done,
    input logic          clear_phase,
    input logic          delay_phase
);

    // R1: a single-port buffer never sees a read and a write together.
    p_no_rw_clash_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re));

    // R2: an accepted pair is followed by the read of its right word.
    p_right_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_ready) |=> (ram_re && !ram_addr[0]));

    // R2: each mix write lands on the address read two cycles before.
    p_wb_same_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !clear_phase) |-> (ram_addr == $past(ram_addr, 2)));

    // R4: the delay phase touches neither the RAM nor the handshake.
    p_delay_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        delay_phase |-> (!ram_we && !ram_re && !smp_ready));

    // R6: the clear sweep only writes zeros.
    p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_phase && ram_we) |-> (ram_wdata == '0));

    // R7: ready only while the RAM is idle.
    p_ready_idle_ram_r7: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |-> (!ram_we && !ram_re));

    // R8: done lasts one cycle.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind mixacc_top mixacc_chk #(.AW(AW), .SW(SW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .smp_ready  (smp_ready),
    .ram_addr   (ram_addr),
    .ram_re     (ram_re),
    .ram_we     (ram_we),
    .ram_wdata  (ram_wdata),
    .done       (done),
    .clear_phase(clear_phase),
    .delay_phase(delay_phase)
);

// File: tb/mixacc_top_tb_top.sv
// Self-checking bench for mixacc_top: walks a table of passes, then runs
// directed reset and corner tests. It models the buffer RAM itself.
module mixacc_top_tb_top;

    localparam int FRAMES = 1024;
    localparam int WORDS  = 2 * FRAMES;
    localparam int NVEC   = 7;

    // Stimulus and expected results: clear, delay, pattern, left-over delay, pairs.
    localparam int V_CLR  [NVEC] = '{1, 0, 0, 1,    0,    0,    0};
    localparam int V_DLY  [NVEC] = '{0, 3, 0, 1023, 1024, 1500, 0};
    localparam int V_PAT  [NVEC] = '{0, 1, 2, 3,    0,    0,    3};
    localparam int V_REM  [NVEC] = '{0, 0, 0, 0,    0,    476,  0};
    localparam int V_PAIRS[NVEC] = '{1024, 1021, 1024, 1, 0, 0, 1024};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        clear_mode = 1'b0;
    logic [31:0] delay_in = '0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_right = '0;
    logic [15:0] smp_left = '0;
    logic        smp_ready;
    logic [10:0] ram_addr;
    logic        ram_re, ram_we;
    logic [15:0] ram_wdata;
    logic [15:0] ram_rdata;
    logic        busy, done;
    logic [31:0] delay_left;

    logic [15:0] mem [WORDS];
    logic [15:0] mdl [WORDS];

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    mixacc_top dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .clear_mode(clear_mode),
        .delay_in(delay_in), .smp_valid(smp_valid), .smp_right(smp_right),
        .smp_left(smp_left), .smp_ready(smp_ready), .ram_addr(ram_addr),
        .ram_re(ram_re), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata), .busy(busy), .done(done), .delay_left(delay_left)
    );

    // Buffer RAM with one-cycle read latency.
    always_ff @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= ram_wdata;
        if (ram_re) ram_rdata <= mem[ram_addr];
    end

    function automatic logic [15:0] gen(int pat, int f, int lr);
        case (pat)
            0:       return 16'(f * 37 - 2000 + lr * 5);
            1:       return (lr != 0) ? 16'h7F00 : 16'h6000;
            2:       return 16'h8000;
            default: return 16'(f * 1021) ^ ((lr != 0) ? 16'h5A5A : 16'h0000);
        endcase
    endfunction

    function automatic logic [15:0] sat16(logic [15:0] a, logic [15:0] b);
        int s;
        s = int'($signed(a)) + int'($signed(b));
        if (s > 32767)  return 16'h7FFF;
        if (s < -32768) return 16'h8000;
        return 16'(s);
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cmp_mem(string req);
        int bad;
        int first;
        bad = 0;
        first = -1;
        for (int i = 0; i < WORDS; i++) begin
            if (mem[i] !== mdl[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        chk(bad == 0, req, "buffer words differing from model (first index shown as expected)",
            bad, first);
    endtask

    task automatic run_pass(int clr, int dly, int pat, int exp_rem, int exp_pairs);
        int  skip;
        int  k;
        int  cyc;
        int  first;
        int  overlap;
        bit  pend;
        bit  seen;
        skip = (dly < FRAMES) ? dly : FRAMES;
        k = 0; cyc = 0; first = -1; overlap = 0; pend = 0; seen = 0;
        if (clr != 0) for (int i = 0; i < WORDS; i++) mdl[i] = 16'h0000;
        for (int f = skip; f < FRAMES; f++) begin
            mdl[2*f]   = sat16(mdl[2*f],   gen(pat, f, 0));
            mdl[2*f+1] = sat16(mdl[2*f+1], gen(pat, f, 1));
        end
        @(negedge clk);
        start = 1'b1; clear_mode = clr[0]; delay_in = 32'(dly);
        @(negedge clk);
        start = 1'b0;
        while (!seen && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (pend) begin k++; pend = 0; end
            if (done) seen = 1;
            if (ram_re && first < 0) first = int'(ram_addr);
            if (smp_ready && (ram_we || ram_re)) overlap++;
            smp_valid = !(pat == 3 && (cyc % 3) == 0);
            smp_right = gen(pat, skip + k, 0);
            smp_left  = gen(pat, skip + k, 1);
            pend = smp_valid && smp_ready;
        end
        smp_valid = 1'b0;
        chk(seen, "R8", "done seen within cycle limit", seen, 1);
        chk(delay_left == 32'(exp_rem), "R5", "left-over delay", delay_left, exp_rem);
        chk(k == exp_pairs, "R7", "pairs accepted", k, exp_pairs);
        chk(overlap == 0, "R7", "ready cycles with RAM access", overlap, 0);
        chk(first == ((exp_pairs > 0) ? 2 * skip : -1), "R4", "first read address",
            first, (exp_pairs > 0) ? 2 * skip : -1);
        @(negedge clk);
        chk(!done, "R8", "done after one cycle", done, 0);
        chk(!busy, "R8", "busy after done", busy, 0);
        cmp_mem((clr != 0) ? "R6/R2" : "R2/R6");
    endtask

    // Global watchdog: an expired run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R8 watchdog: actual timeout expected end of run");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            mem[i] = 16'(i * 7 + 3);
            mdl[i] = 16'(i * 7 + 3);
        end
        repeat (5) @(negedge clk);
        // R9: state held in reset
        chk(!busy && !done && !smp_ready && !ram_we && !ram_re, "R9",
            "control outputs during reset", {busy, done, smp_ready, ram_we, ram_re}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(delay_left == 0 && !busy, "R9", "idle after reset", delay_left, 0);

        for (int v = 0; v < NVEC; v++) begin
            run_pass(V_CLR[v], V_DLY[v], V_PAT[v], V_REM[v], V_PAIRS[v]);
            if (v == 1) begin
                // R3: frame 500 right word saturates high
                chk(mem[1000] == 16'h7FFF, "R3", "high clamp word 1000", mem[1000], 16'h7FFF);
                // R4: frame 0 skipped by the delay of 3
                chk(mem[0] == 16'(-2000), "R4", "skipped frame 0 right", mem[0], 16'(-2000));
            end
            if (v == 2) begin
                chk(mem[0] == 16'h8000, "R3", "low clamp word 0", mem[0], 16'h8000);
                chk(mem[1000] == 16'hFFFF, "R3", "in-range sum word 1000", mem[1000], 16'hFFFF);
            end
            if (v == 3) begin
                // R1: only the last frame carries data after clear with delay 1023
                chk(mem[WORDS-2] == gen(3, FRAMES-1, 0) && mem[WORDS-1] == gen(3, FRAMES-1, 1),
                    "R1", "last frame right then left", mem[WORDS-1], gen(3, FRAMES-1, 1));
                chk(mem[0] == 16'h0000, "R6", "cleared word 0", mem[0], 0);
            end
        end

        // R9: reset in the middle of a pass
        @(negedge clk);
        start = 1'b1; clear_mode = 1'b0; delay_in = 32'd7;
        @(negedge clk);
        start = 1'b0;
        smp_valid = 1'b1; smp_right = 16'h0100; smp_left = 16'h0200;
        repeat (100) @(negedge clk);
        rst_n = 1'b0;
        smp_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(!busy && !done && !smp_ready && !ram_we && !ram_re, "R9",
            "outputs after mid-pass reset", {busy, done, smp_ready, ram_we, ram_re}, 0);
        chk(delay_left == 0, "R9", "delay count after mid-pass reset", delay_left, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R6: a clear pass brings the buffer back to a known state
        run_pass(1, 0, 0, 0, FRAMES);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule